// File: doc/BRIEF.md
# Register-Mapped Random Byte Source

This block lets a host fetch random bytes through three 8-bit registers on a small synchronous register bus. An upstream entropy source hands bytes in over a valid/ready handshake. When the generator is running and no byte is held, the block takes the next byte and raises a data-valid flag. The host polls the control register for that flag and then reads the data register. That read returns the byte and empties the holder, so the next byte can come in.

The generator runs only when two conditions hold together: the enable bit is set and the mode register contains the run code 0x02. The valid flag belongs to the hardware. Writes cannot set or clear it. Only a data read while running, or a control read while stopped, can clear it.

Top module: `rand_byte_periph`

## Requirements
- R1: After reset, the control, mode and data registers are zero, `rnd_ready_o` is low, and `rdata_o` is zero.
- R2: The generator is active only when control bit 0 (enable) is 1 and the mode register equals 0x02. `rnd_ready_o` is high exactly when the generator is active and no byte is held.
- R3: In a cycle where `rnd_ready_o` and `rnd_valid_i` are both high, the block stores `rnd_byte_i` and sets the valid flag. The valid flag appears as bit 1 of the control register (offset 0x000).
- R4: A read of the data register (offset 0x004) while active with a byte held returns that byte. In the same access it clears the valid flag and zeroes the held byte, so an immediate second read returns 0.
- R5: A data register read while inactive or with no byte held returns 0 and changes no state.
- R6: A control register read while the generator is inactive clears the valid flag and returns bit 1 as 0.
- R7: A control register write stores bit 0 (enable), bits 5:2 (prescaler) and bits 7:6 (spare), and reads them back. The valid flag keeps its current value.
- R8: Writes to the data register have no effect.
- R9: A write to the mode register (offset 0x008) stores `wdata_i[7:0]` unchanged, and a read returns that value.
- R10: Reads from any other offset in the 12-bit window return 0, and writes to such offsets have no effect.
- R11: Read data is registered. It appears on `rdata_o` on the clock after the read strobe, zero-extended from 8 bits. `rdata_o` is zero in the cycle after a clock with no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte offset within the register window |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data; only bits 7:0 are used |
| rdata_o | output | 32 | Registered read data |
| rnd_valid_i | input | 1 | Entropy source offers a byte |
| rnd_byte_i | input | 8 | Offered random byte |
| rnd_ready_o | output | 1 | Block will take the offered byte |

## Verification
The assertions make no assumption about the entropy source's protocol: `rnd_valid_i` may rise, fall or repeat in any cycle, and only the handshake cycle counts. They assume the strobes and address are stable around each rising edge. The stimulus meets this by changing every input on the falling edge. Read and write strobes are never raised in the same cycle, which keeps the data-valid property free of a read-side clear. Mode writes favour the run code so that random traffic spends most of its time in the active state.

// File: rtl/rbp_pkg.sv
package rbp_pkg;
  localparam int unsigned OFS_CTRL = 'h000;
  localparam int unsigned OFS_DATA = 'h004;
  localparam int unsigned OFS_MODE = 'h008;
  localparam int unsigned VALID_BIT = 1;
  localparam int unsigned EN_BIT = 0;
  localparam logic [7:0] RUN_MODE = 8'h02;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_DATA,
    SEL_MODE
  } sel_e;
endpackage

// File: rtl/rbp_decode.sv
module rbp_decode
  import rbp_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sel_e              sel_o
);
  always_comb begin
    if (addr_i == ADDR_W'(OFS_CTRL))      sel_o = SEL_CTRL;
    else if (addr_i == ADDR_W'(OFS_DATA)) sel_o = SEL_DATA;
    else if (addr_i == ADDR_W'(OFS_MODE)) sel_o = SEL_MODE;
    else                                  sel_o = SEL_NONE;
  end
endmodule

// File: rtl/rbp_ctrl.sv
module rbp_ctrl
  import rbp_pkg::*;
#(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_ctrl_i,
  input  logic             wr_mode_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] ctrl_o,
  output logic [REG_W-1:0] mode_o,
  output logic             active_o
);
  logic [REG_W-1:0] ctrl_q, mode_q;
  logic [REG_W-1:0] ctrl_d;

  // valid position is not stored here; it lives in the holder
  always_comb begin
    ctrl_d = wdata_i;
    ctrl_d[VALID_BIT] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mode_q <= '0;
    end else begin
      if (wr_ctrl_i) ctrl_q <= ctrl_d;
      if (wr_mode_i) mode_q <= wdata_i;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign mode_o   = mode_q;
  assign active_o = ctrl_q[EN_BIT] && (mode_q == REG_W'(RUN_MODE));
endmodule

// File: rtl/rbp_hold.sv
module rbp_hold #(
  parameter int unsigned REG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             rd_ctrl_i,
  input  logic             rd_data_i,
  input  logic             src_valid_i,
  input  logic [REG_W-1:0] src_byte_i,
  output logic             src_ready_o,
  output logic             valid_o,
  output logic [REG_W-1:0] data_o
);
  logic             valid_q;
  logic [REG_W-1:0] data_q;
  logic             take, consume, drop;

  assign src_ready_o = active_i && !valid_q;
  assign take        = src_ready_o && src_valid_i;
  assign consume     = rd_data_i && active_i && valid_q;
  assign drop        = rd_ctrl_i && !active_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (take) begin
      valid_q <= 1'b1;
      data_q  <= src_byte_i;
    end else if (consume) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (drop) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
endmodule

// File: rtl/rand_byte_periph.sv
module rand_byte_periph
  import rbp_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              rnd_valid_i,
  input  logic [REG_W-1:0]  rnd_byte_i,
  output logic              rnd_ready_o
);
  localparam int unsigned PAD_W = DATA_W - REG_W;

  sel_e             sel;
  logic [REG_W-1:0] ctrl_w, mode_w, data_w, rd_byte;
  logic             active_w, valid_w;
  logic [DATA_W-1:0] rdata_q;

  rbp_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  rbp_ctrl #(.REG_W(REG_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_ctrl_i (we_i && sel == SEL_CTRL),
    .wr_mode_i (we_i && sel == SEL_MODE),
    .wdata_i   (wdata_i[REG_W-1:0]),
    .ctrl_o    (ctrl_w),
    .mode_o    (mode_w),
    .active_o  (active_w)
  );

  rbp_hold #(.REG_W(REG_W)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active_w),
    .rd_ctrl_i   (re_i && sel == SEL_CTRL),
    .rd_data_i   (re_i && sel == SEL_DATA),
    .src_valid_i (rnd_valid_i),
    .src_byte_i  (rnd_byte_i),
    .src_ready_o (rnd_ready_o),
    .valid_o     (valid_w),
    .data_o      (data_w)
  );

  always_comb begin
    rd_byte = '0;
    unique case (sel)
      SEL_CTRL: begin
        rd_byte = ctrl_w;
        rd_byte[VALID_BIT] = valid_w && active_w;
      end
      SEL_DATA: rd_byte = (active_w && valid_w) ? data_w : '0;
      SEL_MODE: rd_byte = mode_w;
      default:  rd_byte = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= {{PAD_W{1'b0}}, rd_byte};
    else           rdata_q <= '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/rbp_checker.sv
module rbp_checker
  import rbp_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [11:0] addr_i,
  input logic        we_i,
  input logic        re_i,
  input logic [31:0] rdata_o,
  input logic        rnd_valid_i,
  input logic [7:0]  rnd_byte_i,
  input logic        rnd_ready_o,
  input logic        active_w,
  input logic        valid_w,
  input logic [7:0]  data_w
);
  logic rd_data, handshake;
  assign rd_data   = re_i && addr_i == 12'(OFS_DATA);
  assign handshake = rnd_ready_o && rnd_valid_i;

  AST_READY_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rnd_ready_o |-> (active_w && !valid_w)); // R2
  AST_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    handshake |=> (valid_w && data_w == $past(rnd_byte_i))); // R3
  AST_CONSUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && active_w && valid_w) |=> (!valid_w && data_w == 8'h00 && rdata_o[7:0] == $past(data_w))); // R4
  AST_EMPTY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data && !(active_w && valid_w)) |=> (rdata_o == 32'h0)); // R5
  AST_WRITE_KEEPS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !re_i && !handshake) |=> (valid_w == $past(valid_w))); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> (rdata_o == 32'h0)); // R11
  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[31:8] == 24'h0); // R11
endmodule

bind rand_byte_periph rbp_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .we_i        (we_i),
  .re_i        (re_i),
  .rdata_o     (rdata_o),
  .rnd_valid_i (rnd_valid_i),
  .rnd_byte_i  (rnd_byte_i),
  .rnd_ready_o (rnd_ready_o),
  .active_w    (active_w),
  .valid_w     (valid_w),
  .data_w      (data_w)
);

// File: tb/tb_rand_byte_periph.sv
`timescale 1ns/1ps
module tb_rand_byte_periph;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rv = 1'b0;
  logic [7:0]  rb = '0;
  logic        rdy;

  int n_chk = 0, n_fail = 0;

  // bench-side register model
  logic [7:0]  m_ctrl = '0, m_mode = '0, m_data = '0;
  logic        m_valid = 1'b0;
  logic [31:0] exp_rd = '0;
  string       exp_tag = "R1";

  always #2.5 clk = ~clk;

  rand_byte_periph dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .re_i(re),
    .wdata_i(wdata), .rdata_o(rdata), .rnd_valid_i(rv), .rnd_byte_i(rb),
    .rnd_ready_o(rdy)
  );

  function automatic logic m_active();
    return m_ctrl[0] && m_mode == 8'h02;
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    logic [7:0] v;
    case (a)
      12'h000: begin v = m_ctrl; v[1] = m_active() && m_valid; end
      12'h004: v = (m_active() && m_valid) ? m_data : 8'h00;
      12'h008: v = m_mode;
      default: v = 8'h00;
    endcase
    return {24'h0, v};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a falling edge; checks last result, drives one cycle, advances model
  task automatic step(input logic w, input logic r, input logic [11:0] a,
                      input logic [31:0] d, input logic v, input logic [7:0] b,
                      input string tag);
    logic act, rdy_m;
    check(exp_tag, rdata, exp_rd);
    rdy_m = m_active() && !m_valid;
    check("R2", {31'h0, rdy}, {31'h0, rdy_m});
    we = w; re = r; addr = a; wdata = d; rv = v; rb = b;
    act = m_active();
    exp_rd = r ? m_read(a) : 32'h0;
    exp_tag = tag;
    if (rdy_m && v) begin m_data = b; m_valid = 1'b1; end
    else if (r && a == 12'h004 && act && m_valid) begin m_valid = 1'b0; m_data = 8'h00; end
    else if (r && a == 12'h000 && !act) m_valid = 1'b0;
    if (w && a == 12'h000) begin m_ctrl = d[7:0]; m_ctrl[1] = 1'b0; end
    if (w && a == 12'h008) m_mode = d[7:0];
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    step(1'b1, 1'b0, a, d, 1'b0, 8'h00, tag);
  endtask
  task automatic rd(input logic [11:0] a, input string tag);
    step(1'b0, 1'b1, a, 32'h0, 1'b0, 8'h00, tag);
  endtask
  task automatic offer(input logic [7:0] b, input string tag);
    step(1'b0, 1'b0, 12'h000, 32'h0, 1'b1, b, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [11:0] addrs [5];
    addrs = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h804};
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    step(1'b0, 1'b0, 12'h000, 32'h0, 1'b0, 8'h00, "R1");
    rd(12'h000, "R1");
    rd(12'h008, "R1");
    rd(12'h004, "R1");
    // R2 enable alone is not enough
    wr(12'h000, 32'h1, "R2");
    offer(8'h77, "R2");
    rd(12'h004, "R5");
    // R3 capture once active
    wr(12'h008, 32'h2, "R2");
    offer(8'hA5, "R3");
    rd(12'h000, "R3");
    // R7 control write keeps valid, prescaler read back
    wr(12'h000, 32'hFFFF_FFFD, "R7");
    rd(12'h000, "R7");
    // R8 data register write ignored
    wr(12'h004, 32'hFF, "R8");
    rd(12'h004, "R4");
    rd(12'h004, "R4");
    // R5/R6 inactive behaviour
    offer(8'h3C, "R3");
    wr(12'h008, 32'h3, "R5");
    rd(12'h004, "R5");
    rd(12'h000, "R6");
    wr(12'h008, 32'h2, "R6");
    rd(12'h004, "R6");
    // R10 unmapped
    wr(12'h00C, 32'hFF, "R10");
    wr(12'h800, 32'hFF, "R10");
    rd(12'h00C, "R10");
    rd(12'h800, "R10");
    rd(12'h008, "R10");
    // R9 mode byte stored as is
    wr(12'h008, 32'hABCD_EF5A, "R9");
    rd(12'h008, "R9");
    wr(12'h008, 32'h2, "R9");
    // R11 random traffic, checks every cycle
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [11:0] a;
      logic [31:0] d;
      op = $urandom_range(0, 9);
      a  = addrs[$urandom_range(0, 4)];
      d  = $urandom;
      if (a == 12'h008 && $urandom_range(0, 3) != 0) d = 32'h2;
      if (a == 12'h000 && $urandom_range(0, 3) != 0) d[0] = 1'b1;
      step(op < 2, op >= 2 && op < 6, a, d, $urandom_range(0, 1) == 1,
           8'($urandom), "R11");
    end
    step(1'b0, 1'b0, 12'h000, 32'h0, 1'b0, 8'h00, "R11");
    check("R11", rdata, exp_rd);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule